// File: doc/BRIEF.md
# Eight-Function Flagging ALU

This block is a combinational arithmetic logic unit for a small 8-bit datapath. It takes a left operand, a right operand, a 3-bit function code and a carry bit from a flag register outside the block. It drives a result bus and four status flags: carry, overflow, zero and negative. There is no clock and nothing is registered. The outputs settle to new values whenever the inputs change. The surrounding control logic latches the flags into its own flag register and decides whether to write the result back.

Four of the functions are bitwise. The other four use a single ripple adder: add, add-with-carry, subtract and compare. Subtract and compare pass the right operand through a row of XOR gates to invert it, and they force the adder carry-in to one, which forms the two's complement. Because the carry-in is used for the two's complement, there is no subtract-with-borrow. Compare produces the same flags as subtract, but it drops its result by holding the write-enable output low.

Top module: `flag_alu`

## Requirements
- R1: Function code 000 drives left AND right, 001 drives left OR right, and 011 drives left XOR right onto the result bus.
- R2: Function code 010 drives the bitwise inverse of the left operand, and the right operand has no effect on any output.
- R3: Function code 101 drives (left + right) mod 256. The carry input has no effect.
- R4: Function code 110 drives (left + right + carryIn) mod 256.
- R5: Function code 111 drives (left - right) mod 256, computed as left + ~right + 1. The carry flag is therefore 1 exactly when left >= right, taken as unsigned values.
- R6: Function code 100 (compare) drives the same result value and flags as function code 111 for the same operands. Its zero flag is 1 exactly when the operands are equal.
- R7: For codes 100 through 111, the carry flag is bit 8 of the 9-bit sum formed by the adder.
- R8: For codes 100 through 111, the overflow flag is 1 exactly when the two adder operands (the right operand already inverted for 100 and 111) have the same sign bit and the result's sign bit differs from it.
- R9: For codes 000 through 011, the carry flag and the overflow flag are both 0.
- R10: The zero flag is 1 exactly when the 8-bit result is 0, for every function code.
- R11: The negative flag equals bit 7 of the result, for every function code.
- R12: The result write-enable output is 0 for code 100 and 1 for every other code.
- R13: All outputs follow the inputs combinationally, with no clock edge between a change at the inputs and the updated outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| leftBus | input | 8 | Left operand |
| rightBus | input | 8 | Right operand |
| opSel | input | 3 | Function code |
| carryIn | input | 1 | Stored carry flag, used only by add-with-carry |
| resultBus | output | 8 | Computed result |
| carryFlag | output | 1 | Unsigned carry out |
| overflowFlag | output | 1 | Signed overflow |
| zeroFlag | output | 1 | Result is zero |
| negFlag | output | 1 | Result sign bit |
| resultWe | output | 1 | Result should be written back |

## Verification
The bench sets the carry input high during plain add. A design that did not tie the adder carry-in low for that code would return a sum one too high. The bench also subtracts equal operands and a larger operand from a smaller one, which pins down the polarity of the carry flag: an adder that inverted the right operand but left carry-in at zero would be off by one, and its zero flag would never set on an equal compare. The bench drives the signed boundaries 0x7F+0x01, 0x80+0x80 and 0x80-0x01. An overflow computed from the carry out alone, rather than from the sign bits, would report the wrong value on those cases. Finally, the bench checks that the logic codes clear carry and overflow, that NOT does not respond to the right bus, and that compare lowers the write enable.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;

  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_AND = 3'b000,
    OP_OR  = 3'b001,
    OP_NOT = 3'b010,
    OP_XOR = 3'b011,
    OP_CMP = 3'b100,
    OP_ADD = 3'b101,
    OP_ADC = 3'b110,
    OP_SUB = 3'b111
  } aluOp_e;

  typedef enum logic [1:0] {
    LOGIC_AND = 2'd0,
    LOGIC_OR  = 2'd1,
    LOGIC_NOT = 2'd2,
    LOGIC_XOR = 2'd3
  } logicFn_e;

  typedef enum logic [1:0] {
    CIN_ZERO = 2'd0,
    CIN_ONE  = 2'd1,
    CIN_FLAG = 2'd2
  } cinMode_e;

  typedef struct packed {
    logicFn_e logicFn;
    logic     useAdder;
    logic     invRight;
    cinMode_e cinMode;
    logic     writeEn;
  } aluStrobes_t;

endpackage

// File: rtl/flag_alu_ctrl.sv
module flag_alu_ctrl
  import flag_alu_pkg::*;
(
  input  logic [OP_W-1:0] opSel,
  output aluStrobes_t     strobes
);

  always_comb begin
    strobes = '{logicFn: LOGIC_AND, useAdder: 1'b0, invRight: 1'b0,
                cinMode: CIN_ZERO, writeEn: 1'b1};
    case (aluOp_e'(opSel))
      OP_AND: strobes.logicFn = LOGIC_AND;
      OP_OR:  strobes.logicFn = LOGIC_OR;
      OP_NOT: strobes.logicFn = LOGIC_NOT;
      OP_XOR: strobes.logicFn = LOGIC_XOR;
      OP_CMP: begin
        strobes.useAdder = 1'b1;
        strobes.invRight = 1'b1;
        strobes.cinMode  = CIN_ONE;
        strobes.writeEn  = 1'b0;
      end
      OP_ADD: begin
        strobes.useAdder = 1'b1;
        strobes.cinMode  = CIN_ZERO;
      end
      OP_ADC: begin
        strobes.useAdder = 1'b1;
        strobes.cinMode  = CIN_FLAG;
      end
      OP_SUB: begin
        strobes.useAdder = 1'b1;
        strobes.invRight = 1'b1;
        strobes.cinMode  = CIN_ONE;
      end
      default: strobes.writeEn = 1'b1;
    endcase
  end

  // R12: only compare drops the result
  always_comb begin
    if (strobes.useAdder && strobes.invRight && !strobes.writeEn)
      assert_cmp_only_R12: assert (opSel == OP_CMP)
        else $error("write enable low for non-compare code");
  end

endmodule

// File: rtl/flag_alu_datapath.sv
module flag_alu_datapath
  import flag_alu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] leftOp,
  input  logic [WIDTH-1:0] rightOp,
  input  logic             carryIn,
  input  aluStrobes_t      strobes,
  output logic [WIDTH-1:0] result,
  output logic             carryOut,
  output logic             overflow,
  output logic             zero,
  output logic             negative
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] logicRes;
  logic [WIDTH-1:0] rightEff;
  logic [WIDTH-1:0] sumBits;
  logic [WIDTH:0]   carryChain;
  logic             adderCin;

  always_comb begin
    case (strobes.logicFn)
      LOGIC_AND: logicRes = leftOp & rightOp;
      LOGIC_OR:  logicRes = leftOp | rightOp;
      LOGIC_NOT: logicRes = ~leftOp;
      LOGIC_XOR: logicRes = leftOp ^ rightOp;
      default:   logicRes = '0;
    endcase
  end

  always_comb begin
    case (strobes.cinMode)
      CIN_ONE:  adderCin = 1'b1;
      CIN_FLAG: adderCin = carryIn;
      default:  adderCin = 1'b0;
    endcase
  end

  assign carryChain[0] = adderCin;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign rightEff[i]     = rightOp[i] ^ strobes.invRight;
    assign sumBits[i]      = leftOp[i] ^ rightEff[i] ^ carryChain[i];
    assign carryChain[i+1] = (leftOp[i] & rightEff[i]) |
                             (carryChain[i] & (leftOp[i] ^ rightEff[i]));
  end

  always_comb begin
    if (strobes.useAdder) begin
      result   = sumBits;
      carryOut = carryChain[WIDTH];
      overflow = carryChain[WIDTH] ^ carryChain[MSB];
    end else begin
      result   = logicRes;
      carryOut = 1'b0;
      overflow = 1'b0;
    end
  end

  assign zero     = (result == '0);
  assign negative = result[MSB];

  // R8: overflow only when operand signs agree and the sum sign disagrees
  always_comb begin
    if (overflow)
      assert_ovf_sign_R8: assert (leftOp[MSB] == rightEff[MSB] && sumBits[MSB] != leftOp[MSB])
        else $error("overflow without sign disagreement");
  end

  // R9: logic functions never raise arithmetic flags
  always_comb begin
    if (!strobes.useAdder)
      assert_logic_noflags_R9: assert (!carryOut && !overflow)
        else $error("arithmetic flag set by logic function");
  end

endmodule

// File: rtl/flag_alu.sv
module flag_alu
  import flag_alu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] leftBus,
  input  logic [WIDTH-1:0] rightBus,
  input  logic [OP_W-1:0]  opSel,
  input  logic             carryIn,
  output logic [WIDTH-1:0] resultBus,
  output logic             carryFlag,
  output logic             overflowFlag,
  output logic             zeroFlag,
  output logic             negFlag,
  output logic             resultWe
);

  aluStrobes_t strobes;

  flag_alu_ctrl i_ctrl (
    .opSel   (opSel),
    .strobes (strobes)
  );

  flag_alu_datapath #(.WIDTH(WIDTH)) i_datapath (
    .leftOp   (leftBus),
    .rightOp  (rightBus),
    .carryIn  (carryIn),
    .strobes  (strobes),
    .result   (resultBus),
    .carryOut (carryFlag),
    .overflow (overflowFlag),
    .zero     (zeroFlag),
    .negative (negFlag)
  );

  assign resultWe = strobes.writeEn;

  // R10/R11: a zero result cannot be negative
  always_comb begin
    if (zeroFlag)
      assert_zero_notneg_R10: assert (!negFlag)
        else $error("zero and negative both set");
  end

  // R2: NOT drives the inverse of the left bus
  always_comb begin
    if (opSel == OP_NOT)
      assert_not_left_R2: assert (resultBus == ~leftBus)
        else $error("NOT result mismatch");
  end

  // R12: compare never requests a write
  always_comb begin
    if (opSel == OP_CMP)
      assert_cmp_nowrite_R12: assert (!resultWe)
        else $error("compare requested write");
  end

endmodule

// File: tb/test_flag_alu.sv
module test_flag_alu;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] leftBus, rightBus;
  logic [2:0] opSel;
  logic       carryIn;
  logic [7:0] resultBus;
  logic       carryFlag, overflowFlag, zeroFlag, negFlag, resultWe;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flag_alu i_flag_alu (
    .leftBus(leftBus), .rightBus(rightBus), .opSel(opSel), .carryIn(carryIn),
    .resultBus(resultBus), .carryFlag(carryFlag), .overflowFlag(overflowFlag),
    .zeroFlag(zeroFlag), .negFlag(negFlag), .resultWe(resultWe)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h (op=%0d l=%0h r=%0h c=%0b)",
               tag, what, act, exp, opSel, leftBus, rightBus, carryIn);
    end
  endtask

  // behavioural reference: returns {we,n,z,v,c,res[7:0]}
  function automatic logic [12:0] model(input int op, input int a, input int b, input int cin);
    int r, bb, s, c, v;
    c = 0; v = 0; bb = b;
    case (op)
      0: r = a & b;
      1: r = a | b;
      2: r = (~a) & 255;
      3: r = a ^ b;
      default: begin
        int ci;
        if (op == 4 || op == 7) begin bb = (~b) & 255; ci = 1; end
        else if (op == 6) ci = cin;
        else ci = 0;
        s = a + bb + ci;
        r = s & 255;
        c = s >> 8;
        v = (((a >> 7) & 1) == ((bb >> 7) & 1) && ((r >> 7) & 1) != ((a >> 7) & 1)) ? 1 : 0;
      end
    endcase
    return {1'(op != 4), 1'(r >> 7), 1'(r == 0), 1'(v), 1'(c), 8'(r)};
  endfunction

  task automatic compareAll();
    logic [12:0] e;
    string rTag;
    bit isLogic;
    e = model(int'(opSel), int'(leftBus), int'(rightBus), int'(carryIn));
    isLogic = (opSel < 4);
    case (opSel)
      3'd2: rTag = "R2";
      3'd4: rTag = "R6";
      3'd5: rTag = "R3";
      3'd6: rTag = "R4";
      3'd7: rTag = "R5";
      default: rTag = "R1";
    endcase
    check(rTag, "result", int'(resultBus), int'(e[7:0]));
    check(isLogic ? "R9" : "R7", "carry", int'(carryFlag), int'(e[8]));
    check(isLogic ? "R9" : "R8", "overflow", int'(overflowFlag), int'(e[9]));
    check("R10", "zero", int'(zeroFlag), int'(e[10]));
    check("R11", "negative", int'(negFlag), int'(e[11]));
    check("R12", "writeEnable", int'(resultWe), int'(e[12]));
  endtask

  task automatic applyVec(input int op, input int a, input int b, input int cin);
    @(posedge clk);
    opSel = 3'(op); leftBus = 8'(a); rightBus = 8'(b); carryIn = 1'(cin);
    @(negedge clk);
    compareAll();
  endtask

  initial begin
    int corner[8] = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'h81, 8'hFE, 8'hFF, 8'h55};
    leftBus = '0; rightBus = '0; opSel = '0; carryIn = 1'b0;
    repeat (2) @(posedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // idle state after reset: AND of zeros
    check("R1", "idle result", int'(resultBus), 0);
    check("R10", "idle zero", int'(zeroFlag), 1);

    // R3: carry input ignored by ADD
    applyVec(5, 8'h10, 8'h20, 1);
    check("R3", "add ignores cin", int'(resultBus), 8'h30);
    // R4: ADC uses cin
    applyVec(6, 8'hFF, 8'h00, 1);
    check("R4", "adc wrap", int'(resultBus), 8'h00);
    check("R7", "adc carry", int'(carryFlag), 1);
    // R5: borrow polarity
    applyVec(7, 8'h05, 8'h05, 0);
    check("R5", "sub equal carry", int'(carryFlag), 1);
    applyVec(7, 8'h03, 8'h05, 0);
    check("R5", "sub smaller carry", int'(carryFlag), 0);
    check("R5", "sub smaller result", int'(resultBus), 8'hFE);
    // R6: compare equal -> zero, no write
    applyVec(4, 8'h42, 8'h42, 0);
    check("R6", "cmp equal zero", int'(zeroFlag), 1);
    check("R12", "cmp no write", int'(resultWe), 0);
    // R8: signed boundaries
    applyVec(5, 8'h7F, 8'h01, 0);
    check("R8", "7F+01 overflow", int'(overflowFlag), 1);
    applyVec(5, 8'h80, 8'h80, 0);
    check("R8", "80+80 overflow", int'(overflowFlag), 1);
    applyVec(7, 8'h80, 8'h01, 0);
    check("R8", "80-01 overflow", int'(overflowFlag), 1);
    // R2: right bus has no effect on NOT
    applyVec(2, 8'h3C, 8'h00, 0);
    applyVec(2, 8'h3C, 8'hFF, 1);
    check("R2", "not ignores right", int'(resultBus), 8'hC3);

    // corner sweep across all codes
    for (int op = 0; op < 8; op++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++)
          applyVec(op, corner[i], corner[j], (i + j) & 1);

    // random patterns
    for (int k = 0; k < 3000; k++)
      applyVec(int'($urandom_range(7)), int'($urandom_range(255)),
               int'($urandom_range(255)), int'($urandom_range(1)));

    // R13: outputs follow inputs with no clock edge in between
    @(negedge clk);
    opSel = 3'd5; leftBus = 8'h01; rightBus = 8'h02; carryIn = 1'b0;
    #1;
    check("R13", "settle 1", int'(resultBus), 8'h03);
    leftBus = 8'h0A;
    #1;
    check("R13", "settle 2", int'(resultBus), 8'h0C);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule